// File: doc/BRIEF.md
# Power-Management Event Window and Interrupt Generator

This block sits beside a bridge's configuration space and does two jobs. First, it decides whether an incoming 16-bit I/O address falls inside a relocatable 64-byte power-management register window. The window base comes from a 32-bit configuration register, of which only the address bits above the 64-byte boundary count. A single enable bit in a configuration byte switches the window on. Both settings are captured into registers, so the window is closed after reset whatever the configuration inputs show. When an address hits, the block also gives the byte offset inside the window.

Second, it keeps the sticky power-management event status word and drives a level-sensitive system control interrupt from it. Event sources set status bits with one-cycle pulses. Software clears them by writing ones. Only four sources are allowed to raise the interrupt: timer overflow, global lock, power button and real-time-clock alarm. A separate timer-arm output tells the free-running timer logic that an overflow event is wanted and has not yet been recorded.

Top module: `pm_sci_window`

## Requirements
- R1: After reset the status word reads 0, the interrupt level and the timer-arm output are 0, and no address hits, even if the configuration inputs already select an enabled window that matches the address.
- R2: An address hits when the registered enable (bit 0 of the enable byte) is 1 and (address AND 0xFFC0) equals (base bits 15..0 AND 0xFFC0). Base bits 31..16, base bits 5..0 and enable-byte bits 7..1 have no effect.
- R3: The offset output always equals address bits 5..0, combinationally.
- R4: Base and enable are sampled on each clock edge. A change in the configuration inputs affects the hit output only after the next rising edge, while the address path stays combinational.
- R5: A 1 on bit i of the event-set input during a clock edge sets status bit i, and the bit stays set until it is cleared.
- R6: A status write whose data has a 1 in bit i clears status bit i. Status bits written with 0 are left unchanged.
- R7: If bit i is set and cleared in the same cycle, the set wins and the bit ends up 1.
- R8: The interrupt level is registered. One edge after the status word and the enable word change, it equals the OR of (status AND enable) over bit positions 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC alarm).
- R9: Status bits at any other position never raise the interrupt, whatever their enable bits hold.
- R10: The timer-arm output is registered. One edge after its inputs change, it is 1 exactly when enable bit 0 is 1 and status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBase | input | 32 | Window base configuration register |
| cfgEnable | input | 8 | Configuration byte; bit 0 enables the window |
| evtEnable | input | 16 | Event enable word |
| evtSet | input | 16 | One-cycle event pulses, one per status bit |
| stsWrEn | input | 1 | Status write strobe |
| stsWrData | input | 16 | Status write data; a 1 clears that bit |
| ioAddr | input | 16 | Incoming I/O address |
| winHit | output | 1 | Address falls inside the enabled window |
| winOffset | output | 6 | Byte offset inside the window |
| sciLevel | output | 1 | Level-sensitive system control interrupt |
| tmrArm | output | 1 | Timer overflow wanted and not yet recorded |
| evtStatus | output | 16 | Current event status word |

## Verification
The bench probes the window at its first and last byte and at the neighbours just outside it. It also moves junk into the ignored base and enable bits, so a design that compared the wrong bit slice, used a wrong size or decoded a wider enable field would miss or hit wrongly. It checks that the interrupt fires for each allowed source and stays low for a status bit outside that set, which catches a wrong source mask or bit positions. It drives a set and a clear into one bit together, and clears one bit while others stay set, which exposes a clear-priority or whole-word clear bug. Finally it checks the outputs exactly one edge after a configuration or enable change, so a missing or extra register stage shows up.

// File: rtl/pm_pkg.sv
package pm_pkg;
  // event word width and fixed source positions
  localparam int EVT_W   = 16;
  localparam int TMR_BIT = 0;
  localparam int GBL_BIT = 5;
  localparam int PWR_BIT = 8;
  localparam int RTC_BIT = 10;

  // positions allowed to raise the interrupt
  localparam logic [EVT_W-1:0] SCI_SRC_MASK =
      (EVT_W'(1) << TMR_BIT) | (EVT_W'(1) << GBL_BIT) |
      (EVT_W'(1) << PWR_BIT) | (EVT_W'(1) << RTC_BIT);

  // strobes from control to datapath
  typedef struct packed {
    logic [EVT_W-1:0] setMask;
    logic [EVT_W-1:0] clrMask;
  } pmStrobe_t;
endpackage

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_W-1:0] evtSet,
  input  logic             stsWrEn,
  input  logic [EVT_W-1:0] stsWrData,
  input  logic [EVT_W-1:0] stsQ,
  input  logic [EVT_W-1:0] evtEnable,
  output pmStrobe_t        strobe,
  output logic             sciLevel,
  output logic             tmrArm
);
  logic             sciQ;
  logic             tmrArmQ;
  logic [EVT_W-1:0] pendMask;

  // strobe generation
  always_comb begin
    strobe.setMask = evtSet;
    strobe.clrMask = stsWrEn ? stsWrData : '0;
  end

  assign pendMask = stsQ & evtEnable & SCI_SRC_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sciQ    <= 1'b0;
      tmrArmQ <= 1'b0;
    end else begin
      sciQ    <= |pendMask;
      tmrArmQ <= evtEnable[TMR_BIT] & ~stsQ[TMR_BIT];
    end
  end

  assign sciLevel = sciQ;
  assign tmrArm   = tmrArmQ;

  AST_SCI_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    sciQ |-> (|($past(stsQ) & $past(evtEnable) & SCI_SRC_MASK))); // R8

  AST_SCI_NOT_OTHERS: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(stsQ) & $past(evtEnable) & SCI_SRC_MASK) == '0) && $past(rstN)) |-> !sciQ); // R9

  AST_TMR_ARM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    tmrArmQ |-> ($past(evtEnable[TMR_BIT]) && !$past(stsQ[TMR_BIT]))); // R10
endmodule

// File: rtl/pm_win_dp.sv
module pm_win_dp
  import pm_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 6,
  parameter int CFG_W    = 32,
  parameter int ENB_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CFG_W-1:0]    cfgBase,
  input  logic [ENB_W-1:0]    cfgEnable,
  input  logic [ADDR_W-1:0]   ioAddr,
  input  pmStrobe_t           strobe,
  output logic                winHit,
  output logic [WIN_LOG2-1:0] winOffset,
  output logic [EVT_W-1:0]    stsQ
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << WIN_LOG2) - ADDR_W'(1));

  logic [ADDR_W-1:0] baseQ;
  logic              winEnQ;
  logic              unusedCfgBits;

  assign unusedCfgBits = ^{cfgBase[CFG_W-1:ADDR_W], cfgEnable[ENB_W-1:1]};

  // configuration capture, window closed after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      winEnQ <= 1'b0;
    end else begin
      baseQ  <= cfgBase[ADDR_W-1:0] & BASE_MASK;
      winEnQ <= cfgEnable[0];
    end
  end

  assign winHit    = winEnQ && ((ioAddr & BASE_MASK) == baseQ);
  assign winOffset = ioAddr[WIN_LOG2-1:0];

  // sticky status, set has priority over write-one-to-clear
  for (genvar gi = 0; gi < EVT_W; gi++) begin : g_sts
    always_ff @(posedge clk) begin
      if (!rstN)                    stsQ[gi] <= 1'b0;
      else if (strobe.setMask[gi])  stsQ[gi] <= 1'b1;
      else if (strobe.clrMask[gi])  stsQ[gi] <= 1'b0;
    end
  end

  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    winHit |-> $past(cfgEnable[0])); // R2

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(stsQ) & ~$past(strobe.clrMask) & ~stsQ) == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(strobe.setMask) & ~stsQ) == '0)); // R7

  AST_CLR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(stsQ) & ~stsQ) & ~$past(strobe.clrMask)) == '0)); // R6
endmodule

// File: rtl/pm_sci_window.sv
module pm_sci_window
  import pm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] cfgBase,
  input  logic [7:0]  cfgEnable,
  input  logic [15:0] evtEnable,
  input  logic [15:0] evtSet,
  input  logic        stsWrEn,
  input  logic [15:0] stsWrData,
  input  logic [15:0] ioAddr,
  output logic        winHit,
  output logic [5:0]  winOffset,
  output logic        sciLevel,
  output logic        tmrArm,
  output logic [15:0] evtStatus
);
  pmStrobe_t        strobe;
  logic [EVT_W-1:0] stsQ;

  pm_evt_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtSet    (evtSet),
    .stsWrEn   (stsWrEn),
    .stsWrData (stsWrData),
    .stsQ      (stsQ),
    .evtEnable (evtEnable),
    .strobe    (strobe),
    .sciLevel  (sciLevel),
    .tmrArm    (tmrArm)
  );

  pm_win_dp #(
    .ADDR_W   (16),
    .WIN_LOG2 (6),
    .CFG_W    (32),
    .ENB_W    (8)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgBase   (cfgBase),
    .cfgEnable (cfgEnable),
    .ioAddr    (ioAddr),
    .strobe    (strobe),
    .winHit    (winHit),
    .winOffset (winOffset),
    .stsQ      (stsQ)
  );

  assign evtStatus = stsQ;
endmodule

// File: tb/test_pm_sci_window.sv
module test_pm_sci_window;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] cfgBase;
  logic [7:0]  cfgEnable;
  logic [15:0] evtEnable;
  logic [15:0] evtSet;
  logic        stsWrEn;
  logic [15:0] stsWrData;
  logic [15:0] ioAddr;
  logic        winHit;
  logic [5:0]  winOffset;
  logic        sciLevel;
  logic        tmrArm;
  logic [15:0] evtStatus;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pm_sci_window i_pm_sci_window (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgEnable(cfgEnable),
    .evtEnable(evtEnable), .evtSet(evtSet), .stsWrEn(stsWrEn),
    .stsWrData(stsWrData), .ioAddr(ioAddr), .winHit(winHit),
    .winOffset(winOffset), .sciLevel(sciLevel), .tmrArm(tmrArm),
    .evtStatus(evtStatus)
  );

  function automatic logic sciModel(logic [15:0] s, logic [15:0] e);
    return |(s & e & 16'h0521);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseEvt(logic [15:0] m);
    evtSet = m;
    settle();
    evtSet = '0;
  endtask

  task automatic writeSts(logic [15:0] m);
    stsWrEn = 1'b1; stsWrData = m;
    settle();
    stsWrEn = 1'b0; stsWrData = '0;
  endtask

  task automatic probe(string req, logic [15:0] a, logic exp);
    ioAddr = a;
    #1;
    chk(req, {15'b0, winHit}, {15'b0, exp});
  endtask

  task automatic testReset();
    // R1: inputs already select a matching enabled window
    chk("R1 status", evtStatus, 16'h0000);
    chk("R1 sci", {15'b0, sciLevel}, 16'h0);
    chk("R1 tmrArm", {15'b0, tmrArm}, 16'h0);
    chk("R1 hit", {15'b0, winHit}, 16'h0);
  endtask

  task automatic testWindow();
    cfgBase = 32'h0000_B000; cfgEnable = 8'h01;
    settle();
    probe("R2 first byte", 16'hB000, 1'b1);
    probe("R2 last byte", 16'hB03F, 1'b1);
    probe("R2 above", 16'hB040, 1'b0);
    probe("R2 below", 16'hAFFF, 1'b0);
    ioAddr = 16'hB02D; #1;
    chk("R3 offset", {10'b0, winOffset}, 16'h002D);
    ioAddr = 16'h1234; #1;
    chk("R3 offset miss", {10'b0, winOffset}, 16'h0034);
    cfgBase = 32'hFFFF_B02A;
    settle();
    probe("R2 ignored base bits", 16'hB000, 1'b1);
    cfgEnable = 8'hFE;
    settle();
    probe("R2 enable bit0 only", 16'hB010, 1'b0);
  endtask

  task automatic testCfgTiming();
    cfgEnable = 8'h01; cfgBase = 32'h0000_4000;
    ioAddr = 16'h4008;
    settle();
    chk("R4 initial", {15'b0, winHit}, 16'h1);
    cfgBase = 32'h0000_4040;
    #1;
    chk("R4 before edge", {15'b0, winHit}, 16'h1);
    settle();
    chk("R4 after edge", {15'b0, winHit}, 16'h0);
    probe("R4 addr comb", 16'h4048, 1'b1);
  endtask

  task automatic testSci();
    evtEnable = 16'hFFFF;
    pulseEvt(16'h0020);
    chk("R5 set", evtStatus, 16'h0020);
    settle();
    chk("R5 sticky", evtStatus, 16'h0020);
    chk("R8 gbl sci", {15'b0, sciLevel}, {15'b0, sciModel(16'h0020, 16'hFFFF)});
    writeSts(16'h0020);
    settle();
    chk("R8 cleared sci", {15'b0, sciLevel}, 16'h0);
    pulseEvt(16'h0002);
    settle();
    chk("R9 status", evtStatus, 16'h0002);
    chk("R9 no sci", {15'b0, sciLevel}, 16'h0);
    writeSts(16'hFFFF);
    evtEnable = 16'h0000;
    pulseEvt(16'h0100);
    settle();
    chk("R8 masked", {15'b0, sciLevel}, 16'h0);
    evtEnable = 16'h0100;
    #1;
    chk("R8 before edge", {15'b0, sciLevel}, 16'h0);
    settle();
    chk("R8 pwr sci", {15'b0, sciLevel}, 16'h1);
    writeSts(16'h0100);
    evtEnable = 16'h0400;
    pulseEvt(16'h0400);
    settle();
    chk("R8 rtc sci", {15'b0, sciLevel}, 16'h1);
    writeSts(16'hFFFF);
    settle();
  endtask

  task automatic testW1c();
    pulseEvt(16'h0121);
    writeSts(16'h0020);
    chk("R6 partial clear", evtStatus, 16'h0101);
    writeSts(16'h0000);
    chk("R6 zero write", evtStatus, 16'h0101);
    stsWrEn = 1'b1; stsWrData = 16'h0400; evtSet = 16'h0400;
    settle();
    stsWrEn = 1'b0; stsWrData = '0; evtSet = '0;
    chk("R7 set wins", evtStatus, 16'h0501);
    writeSts(16'hFFFF);
    chk("R6 full clear", evtStatus, 16'h0000);
  endtask

  task automatic testTimer();
    evtEnable = 16'h0001;
    settle();
    chk("R10 armed", {15'b0, tmrArm}, 16'h1);
    pulseEvt(16'h0001);
    settle();
    chk("R10 disarmed", {15'b0, tmrArm}, 16'h0);
    chk("R8 tmr sci", {15'b0, sciLevel}, 16'h1);
    writeSts(16'h0001);
    settle();
    chk("R10 rearmed", {15'b0, tmrArm}, 16'h1);
    evtEnable = 16'h0000;
    settle();
    chk("R10 enable off", {15'b0, tmrArm}, 16'h0);
  endtask

  initial begin
    rstN = 1'b0;
    cfgBase = 32'h0000_B000; cfgEnable = 8'h01; ioAddr = 16'hB000;
    evtEnable = 16'hFFFF; evtSet = 16'hFFFF;
    stsWrEn = 1'b0; stsWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    evtSet = '0; evtEnable = '0;
    rstN = 1'b1;
    settle();
    testWindow();
    testCfgTiming();
    testSci();
    testW1c();
    testTimer();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule